// File: doc/BRIEF.md
# Cascaded Integrator Pair for 1-Bit Stream Demodulation

This block holds two 32-bit phase accumulators driven from two pins. In independent mode each accumulator adds its own increment register on every enabled clock on which its synchronized pin is high. In chained mode the first accumulator still integrates its pin, but the second adds the first accumulator's running total on every enabled clock. The pair then forms a double integrator for a 1-bit sigma-delta bitstream.

Software takes snapshots of both totals at a fixed decimation interval. It recovers the input level from the second difference of successive readings of the second total. Wrap-around modulo 2^32 cancels in those differences.

Each snapshot is captured coherently in one clock and offered on a valid/ready output. A captured snapshot stays on the output, unchanged, until the consumer accepts it with ready. A snapshot request made while an unaccepted snapshot is still held is dropped. A request made in the same cycle as an acceptance is taken. The differencing itself is done outside the block.

Top module: `cascade_integ_pair`

## Requirements
- R1: After reset both accumulators and both increment registers are zero, chaining is off and `snap_valid_o` is 0.
- R2: Each pin passes through two register stages. A pin level applied before clock edge k decides the accumulation at edge k+2. At that edge the first accumulator adds its increment register if the synchronized `pin_a_i` is 1 and `clk_en_i` is 1.
- R3: With chaining off (`mode_chain_i`=0 at the last mode write), the second accumulator adds its own increment register on enabled clocks with synchronized `pin_b_i` high, independently of the first.
- R4: With chaining on (`mode_chain_i`=1), the second accumulator adds the first accumulator's value from before the same edge's update on every enabled clock, and `pin_b_i` and the second increment register have no effect.
- R5: While `clk_en_i` is 0, neither accumulator changes, except when a mode write clears them.
- R6: A mode write (`mode_wr_i`=1) clears both accumulators at that edge and loads the chaining bit. An increment write (`frq_wr_i`; `frq_sel_i`=0 selects the first accumulator's register, 1 the second) is first used at the following edge.
- R7: Both accumulators wrap modulo 2^32.
- R8: A snapshot takes both accumulator values as they stand before the capturing edge's update. While `snap_valid_o`=1 and `snap_ready_i`=0, the output data and valid do not change.
- R9: A `snap_req_i` is taken when no snapshot is held, or when the held one is accepted in the same cycle. Otherwise it is dropped. With no request, an accepted snapshot clears `snap_valid_o`.
- R10: In chained mode, with a pin pattern whose period divides the decimation interval D, the second difference of the second accumulator's snapshots equals D times the first accumulator's growth over D cycles, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | External accumulation enable |
| pin_a_i | input | 1 | Bitstream pin for the first accumulator |
| pin_b_i | input | 1 | Bitstream pin for the second accumulator (independent mode) |
| mode_wr_i | input | 1 | Mode write strobe; clears both accumulators |
| mode_chain_i | input | 1 | Chaining bit loaded by a mode write |
| frq_wr_i | input | 1 | Increment register write strobe |
| frq_sel_i | input | 1 | 0: first increment register, 1: second |
| frq_data_i | input | 32 | Increment value to write |
| snap_req_i | input | 1 | Snapshot request |
| snap_valid_o | output | 1 | Snapshot held on the output |
| snap_ready_i | input | 1 | Consumer accepts the held snapshot |
| snap_a_o | output | 32 | Captured first accumulator |
| snap_b_o | output | 32 | Captured second accumulator |

## Verification
The hardest situation to reach is a request dropped against back-pressure while the accumulators are still moving, together with a chained sum that has wrapped. The bench holds ready low at random while requests arrive every cycle. A per-cycle reference model decides which requests are taken, and the values pushed for comparison come from that model. For second-order recovery, a periodic pin pattern with a large increment runs the totals through many wraps. Snapshots at a fixed interval are then checked by double differencing against the closed-form value.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int unsigned CIP_ACC_W   = 32;
  localparam int unsigned CIP_SYNC_N  = 2;
  localparam int unsigned CIP_NUM_PIN = 2;

  typedef enum logic {
    MODE_INDEP = 1'b0,
    MODE_CHAIN = 1'b1
  } cip_mode_e;

  typedef enum logic {
    SEL_FIRST  = 1'b0,
    SEL_SECOND = 1'b1
  } cip_sel_e;

  localparam int unsigned PIN_FIRST  = 0;
  localparam int unsigned PIN_SECOND = 1;
endpackage

// File: rtl/cip_pin_sync.sv
module cip_pin_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else begin
        if (s == 0) stage_q[s] <= async_i;
        else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cip_accum.sv
module cip_accum #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         add_i,
  input  logic [W-1:0] addend_i,
  output logic [W-1:0] acc_o
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            acc_q <= '0;
    else if (clr_i)         acc_q <= '0;
    else if (en_i && add_i) acc_q <= acc_q + addend_i;
  end

  assign acc_o = acc_q;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(acc_q)); // R5
  AST_CLEAR_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0)); // R6
endmodule

// File: rtl/cip_snapshot.sv
module cip_snapshot #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  logic         valid_q;
  logic [W-1:0] a_q, b_q;
  logic         take;

  assign take = req_i && (!valid_q || ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      a_q     <= a_i;
      b_q     <= b_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign a_o     = a_q;
  assign b_o     = b_q;

  AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(a_q) && $stable(b_q))); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !valid_q) |=> !valid_q); // R9
endmodule

// File: rtl/cascade_integ_pair.sv
module cascade_integ_pair
  import cip_pkg::*;
#(
  parameter int unsigned ACC_W  = CIP_ACC_W,
  parameter int unsigned SYNC_N = CIP_SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic             mode_wr_i,
  input  logic             mode_chain_i,
  input  logic             frq_wr_i,
  input  logic             frq_sel_i,
  input  logic [ACC_W-1:0] frq_data_i,
  input  logic             snap_req_i,
  output logic             snap_valid_o,
  input  logic             snap_ready_i,
  output logic [ACC_W-1:0] snap_a_o,
  output logic [ACC_W-1:0] snap_b_o
);
  localparam int unsigned NPIN = CIP_NUM_PIN;

  logic [NPIN-1:0]  pins_raw, pins_s;
  cip_mode_e        mode_q;
  logic [ACC_W-1:0] frq_a_q, frq_b_q;
  logic [ACC_W-1:0] acc_a, acc_b;
  logic             chained;
  logic             b_add;
  logic [ACC_W-1:0] b_addend;

  assign pins_raw[PIN_FIRST]  = pin_a_i;
  assign pins_raw[PIN_SECOND] = pin_b_i;

  cip_pin_sync #(.STAGES(SYNC_N), .WIDTH(NPIN)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pins_raw),
    .sync_o  (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_INDEP;
      frq_a_q <= '0;
      frq_b_q <= '0;
    end else begin
      if (mode_wr_i) mode_q <= cip_mode_e'(mode_chain_i);
      if (frq_wr_i) begin
        if (cip_sel_e'(frq_sel_i) == SEL_SECOND) frq_b_q <= frq_data_i;
        else                                     frq_a_q <= frq_data_i;
      end
    end
  end

  assign chained  = (mode_q == MODE_CHAIN);
  assign b_add    = chained ? 1'b1  : pins_s[PIN_SECOND];
  assign b_addend = chained ? acc_a : frq_b_q;

  cip_accum #(.W(ACC_W)) u_acc_a (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mode_wr_i),
    .en_i     (clk_en_i),
    .add_i    (pins_s[PIN_FIRST]),
    .addend_i (frq_a_q),
    .acc_o    (acc_a)
  );

  cip_accum #(.W(ACC_W)) u_acc_b (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mode_wr_i),
    .en_i     (clk_en_i),
    .add_i    (b_add),
    .addend_i (b_addend),
    .acc_o    (acc_b)
  );

  cip_snapshot #(.W(ACC_W)) u_snap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (snap_req_i),
    .a_i     (acc_a),
    .b_i     (acc_b),
    .valid_o (snap_valid_o),
    .ready_i (snap_ready_i),
    .a_o     (snap_a_o),
    .b_o     (snap_b_o)
  );

  AST_FIRST_ADDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && !mode_wr_i && pins_s[PIN_FIRST] && !frq_wr_i)
    |=> (acc_a == $past(acc_a) + frq_a_q)); // R2
  AST_CHAIN_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chained && clk_en_i && !mode_wr_i)
    |=> (acc_b == $past(acc_b) + $past(acc_a))); // R4
  AST_INDEP_IDLE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chained && !pins_s[PIN_SECOND] && !mode_wr_i) |=> $stable(acc_b)); // R3
endmodule

// File: tb/cascade_integ_pair_tb.sv
module cascade_integ_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
  } snap_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en = 1'b1, pin_a = 1'b0, pin_b = 1'b0;
  logic mode_wr = 1'b0, mode_chain = 1'b0;
  logic frq_wr = 1'b0, frq_sel = 1'b0;
  logic [W-1:0] frq_data = '0;
  logic snap_req = 1'b0, snap_ready = 1'b1;
  logic snap_valid;
  logic [W-1:0] snap_a, snap_b;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  snap_t sb_q[$];
  logic [W-1:0] rec_b[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_integ_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en),
    .pin_a_i(pin_a), .pin_b_i(pin_b),
    .mode_wr_i(mode_wr), .mode_chain_i(mode_chain),
    .frq_wr_i(frq_wr), .frq_sel_i(frq_sel), .frq_data_i(frq_data),
    .snap_req_i(snap_req), .snap_valid_o(snap_valid), .snap_ready_i(snap_ready),
    .snap_a_o(snap_a), .snap_b_o(snap_b)
  );

  task automatic chk(input bit ok, input string t, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  // Reference model of the requirements, stepped at each edge
  logic s1a, s2a, s1b, s2b, m_chain, m_v;
  logic [W-1:0] m_a, m_b, m_fa, m_fb;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1a <= 0; s2a <= 0; s1b <= 0; s2b <= 0; m_chain <= 0; m_v <= 0;
      m_a <= '0; m_b <= '0; m_fa <= '0; m_fb <= '0;
    end else begin
      s1a <= pin_a; s2a <= s1a; s1b <= pin_b; s2b <= s1b;
      if (mode_wr) begin
        m_a <= '0; m_b <= '0; m_chain <= mode_chain;
      end else if (clk_en) begin
        if (s2a) m_a <= m_a + m_fa;
        if (m_chain)  m_b <= m_b + m_a;
        else if (s2b) m_b <= m_b + m_fb;
      end
      if (frq_wr) begin
        if (frq_sel) m_fb <= frq_data; else m_fa <= frq_data;
      end
      if (snap_req && (!m_v || snap_ready)) begin
        sb_q.push_back('{a: m_a, b: m_b});
        m_v <= 1'b1;
      end else if (snap_ready) begin
        m_v <= 1'b0;
      end
    end
  end

  // Monitor: pops expected snapshots as the design hands them over
  logic p_v = 0, p_r = 0;
  logic [W-1:0] p_a = '0, p_b = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(snap_valid == m_v, "R9", "valid flag", W'(snap_valid), W'(m_v));
      if (p_v && !p_r) begin
        chk(snap_valid && snap_a == p_a && snap_b == p_b, "R8", "held snapshot",
            snap_b, p_b);
      end
      if (snap_valid && snap_ready) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, tag, "unexpected snapshot", snap_b, '0);
        end else begin
          snap_t e;
          e = sb_q.pop_front();
          chk(snap_a == e.a, tag, "first total", snap_a, e.a);
          chk(snap_b == e.b, tag, "second total", snap_b, e.b);
          if (tag == "R10") rec_b.push_back(snap_b);
        end
      end
    end
    p_v = snap_valid; p_r = snap_ready; p_a = snap_a; p_b = snap_b;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_mode(input bit chain);
    mode_wr = 1'b1; mode_chain = chain; step(); mode_wr = 1'b0;
  endtask

  task automatic write_frq(input bit sel, input logic [W-1:0] d);
    frq_wr = 1'b1; frq_sel = sel; frq_data = d; step(); frq_wr = 1'b0;
  endtask

  task automatic drive(input int n, input int every, input bit rnd_en, input bit rnd_rdy);
    for (int i = 0; i < n; i++) begin
      pin_a = 1'($urandom); pin_b = 1'($urandom);
      clk_en = rnd_en ? 1'($urandom) : 1'b1;
      snap_ready = rnd_rdy ? 1'($urandom) : 1'b1;
      snap_req = (every == 0) ? 1'b1 : (i % every == 0);
      step();
    end
    snap_req = 1'b0; snap_ready = 1'b1; clk_en = 1'b1;
    step(); step();
  endtask

  bit done = 0;
  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] f, d2, exp;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1: reset state
    tag = "R1";
    chk(snap_valid == 1'b0, "R1", "valid after reset", W'(snap_valid), '0);
    snap_req = 1'b1; step(); snap_req = 1'b0; step();
    // R2 and R3: independent accumulation
    tag = "R3";
    write_frq(1'b0, 32'd3); write_frq(1'b1, 32'd5);
    write_mode(1'b0);
    drive(60, 3, 1'b0, 1'b0);
    tag = "R2";
    write_frq(1'b0, 32'd11);
    drive(40, 2, 1'b0, 1'b0);
    // R5: random enable
    tag = "R5";
    drive(80, 3, 1'b1, 1'b0);
    // R6: mode and increment writes mid-stream
    tag = "R6";
    for (int k = 0; k < 4; k++) begin
      drive(10, 2, 1'b0, 1'b0);
      write_frq(1'($urandom), $urandom);
      snap_req = 1'b1; write_mode(1'(k)); snap_req = 1'b0;
    end
    // R4: chained mode, pin_b toggling
    tag = "R4";
    write_frq(1'b0, 32'd7); write_mode(1'b1);
    drive(80, 4, 1'b0, 1'b0);
    // R7: wrap with large increments
    tag = "R7";
    write_frq(1'b0, 32'hF000_0001); write_frq(1'b1, 32'hFFFF_FFF0);
    write_mode(1'b0); drive(40, 3, 1'b0, 1'b0);
    write_mode(1'b1); drive(40, 3, 1'b0, 1'b0);
    // R8 and R9: back-pressure with requests every cycle
    tag = "R9";
    drive(200, 0, 1'b1, 1'b1);
    // R10: second-order recovery through double differencing
    tag = "R10";
    f = 32'h1234_5679;
    write_frq(1'b0, f); write_mode(1'b1);
    for (int i = 0; i < 16 * 6; i++) begin
      pin_a = ((i % 4) < 2);
      snap_req = (i >= 16) && (i % 16 == 0);
      snap_ready = 1'b1; clk_en = 1'b1;
      step();
    end
    snap_req = 1'b0; step(); step();
    tag = "R10x";
    exp = f * 32'd128;
    chk(rec_b.size() == 5, "R10", "snapshot count", W'(rec_b.size()), 32'd5);
    if (rec_b.size() == 5) begin
      for (int j = 0; j < 3; j++) begin
        d2 = rec_b[j+2] - 32'd2 * rec_b[j+1] + rec_b[j];
        chk(d2 == exp, "R10", "second difference", d2, exp);
      end
    end
    chk(sb_q.size() == 0, "R9", "pending expected items", W'(sb_q.size()), '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule